// File: doc/BRIEF.md
# Two-Level Priority Interrupt Arbiter

The arbiter takes a bank of maskable interrupt lines, each gated by its own enable bit and assigned to a low or high priority level by a one-bit level setting. A separate non-maskable line is also an input. On every cycle the arbiter picks one winner. The non-maskable request comes first. After it, any high-level source beats any low-level source. Within a level, the lowest-numbered source wins.

The winner is then tested against the CPU's two mask bits, called "I" and "UI" below, which form three regimes:
- Open: every request may be taken.
- High-only: only high-level requests may be taken.
- Closed: only the non-maskable request may be taken.

A request is taken only on a cycle where the CPU marks an instruction boundary. The result appears one clock later as a single-cycle accept pulse. With it come the vector number of the source and a command that tells the CPU to set both mask bits.

Maskable lines are level-sensitive, and the peripheral clears them, so a request that loses or is masked simply stays on its line until a later boundary. The non-maskable line is edge-detected and latched. The latch clears when that request is taken.

Top module: `prio_irq_arbiter`

## Requirements
- R1: A maskable source takes part in arbitration only while both its condition line and its enable bit are 1.
- R2: A requesting source whose level bit is 1 wins over every requesting source whose level bit is 0.
- R3: Among requesting sources at the same level, the lowest index wins, and the vector output is VEC_BASE plus that index.
- R4: With cpu_i_i = 0, the winning maskable request is accepted at either level, whatever the value of cpu_ui_i.
- R5: With cpu_i_i = 1 and cpu_ui_i = 0, a winner is accepted only if its level bit is 1. Otherwise nothing is accepted.
- R6: With cpu_i_i = 1 and cpu_ui_i = 1, no maskable request is accepted.
- R7: accept_o pulses for one cycle, in the clock after a cycle where insn_end_i = 1 and some request was acceptable. It stays 0 after any cycle with insn_end_i = 0. vector_o is 0 whenever accept_o is 0.
- R8: set_mask_o is 1 in exactly the cycles where accept_o is 1.
- R9: A 0-to-1 transition on nmi_i is latched. The next boundary then accepts it regardless of the mask bits and ahead of any maskable request, and vector_o carries NMI_VEC.
- R10: Taking the non-maskable request clears its latch. If nmi_i is held high afterwards, there is no second accept.
- R11: A maskable request that was held back is accepted at a later boundary once the masks allow it. Nothing is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_cond_i | input | N_SRC | Interrupt condition lines, level-sensitive |
| irq_en_i | input | N_SRC | Per-source enable bits |
| irq_lvl_i | input | N_SRC | Per-source priority level (1 = high) |
| nmi_i | input | 1 | Non-maskable request, edge-detected |
| cpu_i_i | input | 1 | CPU mask bit I |
| cpu_ui_i | input | 1 | CPU mask bit UI |
| insn_end_i | input | 1 | Instruction-boundary strobe |
| accept_o | output | 1 | One-cycle acceptance pulse |
| vector_o | output | VEC_W | Vector number of the accepted request |
| set_mask_o | output | 1 | Command to set both I and UI |

## Verification
The bench builds the arbiter with N_SRC = 8, VEC_W = 6, VEC_BASE = 16 and NMI_VEC = 3. With this setting the vectors for the maskable sources (16 to 23) and the non-maskable vector can never overlap, so a single comparison shows which branch won. The eight sources are enough to put two high-level and two low-level requests up at once. That covers both the tie-break inside a level and the override between levels, along with every state of the mask bits and non-maskable edges that arrive while a maskable request is waiting.

// File: rtl/irq_arb_pkg.sv
`timescale 1ns/1ps
package irq_arb_pkg;

  typedef enum logic [1:0] {
    RG_OPEN   = 2'd0,
    RG_HIGH   = 2'd1,
    RG_CLOSED = 2'd2
  } regime_e;

  function automatic regime_e regime_of(logic i_bit, logic ui_bit);
    if (!i_bit)      return RG_OPEN;
    else if (!ui_bit) return RG_HIGH;
    else             return RG_CLOSED;
  endfunction

endpackage

// File: rtl/irq_lowest_pick.sv
`timescale 1ns/1ps
module irq_lowest_pick #(
  parameter int N_SRC = 16,
  localparam int IW = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] req_i,
  output logic             hit_o,
  output logic [IW-1:0]    idx_o
);

  // scan downward so the lowest set index is the last one written
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int k = N_SRC - 1; k >= 0; k--) begin
      if (req_i[k]) begin
        hit_o = 1'b1;
        idx_o = IW'(k);
      end
    end
  end

endmodule

// File: rtl/irq_mask_gate.sv
`timescale 1ns/1ps
module irq_mask_gate
  import irq_arb_pkg::*;
(
  input  logic cpu_i_i,
  input  logic cpu_ui_i,
  input  logic win_hi_i,
  output logic pass_o
);

  regime_e regime;

  always_comb begin
    regime = regime_of(cpu_i_i, cpu_ui_i);
    unique case (regime)
      RG_OPEN: pass_o = 1'b1;
      RG_HIGH: pass_o = win_hi_i;
      default: pass_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/irq_nmi_latch.sv
`timescale 1ns/1ps
module irq_nmi_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nmi_i,
  input  logic take_i,
  output logic pend_o
);

  logic nmi_q;
  logic rise;

  assign rise = nmi_i & ~nmi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nmi_q  <= 1'b0;
      pend_o <= 1'b0;
    end else begin
      nmi_q  <= nmi_i;
      // a fresh edge wins over a clear in the same cycle
      pend_o <= rise | (pend_o & ~take_i);
    end
  end

  AST_NMI_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o && take_i && !(nmi_i && !nmi_q)) |=> !pend_o); // R10

endmodule

// File: rtl/prio_irq_arbiter.sv
`timescale 1ns/1ps
module prio_irq_arbiter #(
  parameter int N_SRC    = 16,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 32,
  parameter int NMI_VEC  = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] irq_cond_i,
  input  logic [N_SRC-1:0] irq_en_i,
  input  logic [N_SRC-1:0] irq_lvl_i,
  input  logic             nmi_i,
  input  logic             cpu_i_i,
  input  logic             cpu_ui_i,
  input  logic             insn_end_i,
  output logic             accept_o,
  output logic [VEC_W-1:0] vector_o,
  output logic             set_mask_o
);

  localparam int IW = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  localparam logic [VEC_W-1:0] NMI_V  = VEC_W'(NMI_VEC);
  localparam logic [VEC_W-1:0] BASE_V = VEC_W'(VEC_BASE);

  logic [N_SRC-1:0] req;
  logic [N_SRC-1:0] lvl_req [2];
  logic [1:0]       lvl_hit;
  logic [IW-1:0]    lvl_idx [2];
  logic [IW-1:0]    win_idx;
  logic             any_req;
  logic             pass;
  logic             nmi_pend;
  logic             take_nmi;
  logic             take_msk;
  logic [VEC_W-1:0] vec_d;

  assign req        = irq_cond_i & irq_en_i;
  assign lvl_req[1] = req & irq_lvl_i;
  assign lvl_req[0] = req & ~irq_lvl_i;

  for (genvar g = 0; g < 2; g++) begin : g_lvl
    irq_lowest_pick #(.N_SRC(N_SRC)) u_pick (
      .req_i (lvl_req[g]),
      .hit_o (lvl_hit[g]),
      .idx_o (lvl_idx[g])
    );
  end

  assign any_req = |lvl_hit;
  assign win_idx = lvl_hit[1] ? lvl_idx[1] : lvl_idx[0];

  irq_mask_gate u_gate (
    .cpu_i_i  (cpu_i_i),
    .cpu_ui_i (cpu_ui_i),
    .win_hi_i (lvl_hit[1]),
    .pass_o   (pass)
  );

  irq_nmi_latch u_nmi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .nmi_i  (nmi_i),
    .take_i (take_nmi),
    .pend_o (nmi_pend)
  );

  assign take_nmi = insn_end_i & nmi_pend;
  assign take_msk = insn_end_i & ~nmi_pend & any_req & pass;

  always_comb begin
    if (take_nmi)      vec_d = NMI_V;
    else if (take_msk) vec_d = BASE_V + VEC_W'(win_idx);
    else               vec_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      accept_o   <= 1'b0;
      set_mask_o <= 1'b0;
      vector_o   <= '0;
    end else begin
      accept_o   <= take_nmi | take_msk;
      set_mask_o <= take_nmi | take_msk;
      vector_o   <= vec_d;
    end
  end

  AST_ACC_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> $past(insn_end_i)); // R7

  AST_CLOSED_NMI_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && $past(cpu_i_i && cpu_ui_i)) |-> (vector_o == NMI_V)); // R6

  AST_NMI_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(insn_end_i && nmi_pend) |-> (accept_o && vector_o == NMI_V)); // R9

  AST_ACC_SETS_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(insn_end_i && any_req && !cpu_i_i) |-> (accept_o && set_mask_o)); // R4

endmodule

// File: tb/prio_irq_arbiter_bench.sv
`timescale 1ns/1ps
module prio_irq_arbiter_bench;

  localparam int N   = 8;
  localparam int VW  = 6;
  localparam int VB  = 16;
  localparam int NV  = 3;

  typedef struct packed {
    logic [7:0] cond;
    logic [7:0] en;
    logic [7:0] lvl;
    logic       ci;
    logic       cui;
    logic       acc;
    logic [5:0] vec;
  } vec_t;

  // cond, en, lvl, I, UI, accept, vector
  localparam vec_t TBL [9] = '{
    '{8'h0F, 8'h0A, 8'h00, 1'b0, 1'b0, 1'b1, 6'd17}, // R1 R3
    '{8'h30, 8'hFF, 8'h20, 1'b0, 1'b0, 1'b1, 6'd21}, // R2
    '{8'hC0, 8'hFF, 8'hC0, 1'b0, 1'b0, 1'b1, 6'd22}, // R3
    '{8'h01, 8'hFF, 8'h00, 1'b1, 1'b0, 1'b0, 6'd0 }, // R5
    '{8'h81, 8'hFF, 8'h80, 1'b1, 1'b0, 1'b1, 6'd23}, // R5
    '{8'h81, 8'hFF, 8'h80, 1'b1, 1'b1, 1'b0, 6'd0 }, // R6
    '{8'h04, 8'hFF, 8'h00, 1'b0, 1'b1, 1'b1, 6'd18}, // R4
    '{8'h00, 8'hFF, 8'hFF, 1'b0, 1'b0, 1'b0, 6'd0 }, // R7
    '{8'hFF, 8'h00, 8'hFF, 1'b0, 1'b0, 1'b0, 6'd0 }  // R1
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  cond = '0, en = '0, lvl = '0;
  logic          nmi = 1'b0, ci = 1'b0, cui = 1'b0, iend = 1'b0;
  logic          acc, setm;
  logic [VW-1:0] vec;
  int            n_chk = 0;
  int            n_bad = 0;

  always #2.5 clk = ~clk;

  prio_irq_arbiter #(.N_SRC(N), .VEC_W(VW), .VEC_BASE(VB), .NMI_VEC(NV)) u_prio_irq_arbiter (
    .clk_i(clk), .rst_ni(rst_n), .irq_cond_i(cond), .irq_en_i(en), .irq_lvl_i(lvl),
    .nmi_i(nmi), .cpu_i_i(ci), .cpu_ui_i(cui), .insn_end_i(iend),
    .accept_o(acc), .vector_o(vec), .set_mask_o(setm)
  );

  task automatic chk(input string rq, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", rq, act, exp);
    end
  endtask

  // one boundary cycle, outputs checked at the following negedge
  task automatic boundary(input string rq, input logic e_acc, input int e_vec);
    @(negedge clk) iend = 1'b1;
    @(negedge clk) iend = 1'b0;
    chk(rq, int'(acc), int'(e_acc));
    chk(rq, int'(vec), e_vec);
    chk({rq, "/R8"}, int'(setm), int'(e_acc));
  endtask

  initial begin
    #250000;
    n_bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R7 reset acc", int'(acc), 0);
    chk("R7 reset vec", int'(vec), 0);
    chk("R8 reset set", int'(setm), 0);
    rst_n = 1'b1;

    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      cond = TBL[i].cond; en = TBL[i].en; lvl = TBL[i].lvl;
      ci = TBL[i].ci; cui = TBL[i].cui;
      boundary($sformatf("tbl%0d", i), TBL[i].acc, int'(TBL[i].vec));
    end

    // R7: request present, no boundary
    cond = 8'h01; en = 8'hFF; lvl = 8'h00; ci = 1'b0; cui = 1'b0;
    repeat (2) begin
      @(negedge clk);
      chk("R7 no boundary", int'(acc), 0);
      chk("R7 idle vec", int'(vec), 0);
    end

    // R11: held while closed, accepted once opened
    ci = 1'b1; cui = 1'b1;
    boundary("R11 held", 1'b0, 0);
    ci = 1'b0; cui = 1'b0;
    boundary("R11 served", 1'b1, 16);

    // R9: NMI through closed masks, ahead of maskable
    ci = 1'b1; cui = 1'b1;
    @(negedge clk) nmi = 1'b1;
    boundary("R9 nmi closed", 1'b1, NV);
    // R10: held-high NMI does not request again
    boundary("R10 no repeat", 1'b0, 0);
    @(negedge clk) nmi = 1'b0;
    @(negedge clk) nmi = 1'b1;
    ci = 1'b0; cui = 1'b0; cond = 8'h02;
    boundary("R9 nmi first", 1'b1, NV);
    boundary("R11 maskable after nmi", 1'b1, 17);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule